// File: doc/BRIEF.md
# Standby State Sequencer

This block decides the power state of a small microcontroller and gates its clock domains to match. It has five states: running, sleeping, stopped, and two reset holds. The one that clears the settings is the setting reset (INIT). The one that keeps them is the operation reset (RST). Software reaches the block through a plain register port with two registers: a standby register and a timebase register. Interrupt sources present a request bit and a 4-bit priority level. Two reset request lines force the reset holds.

Sleep stops only the CPU clock. The peripheral domain keeps running, because it holds the interrupt logic, timers and DMA. The bus/memory clock turns on only while a DMA request is active. Stop turns off every gated clock.

When the synchronous standby bit is set, writing the sleep bit only arms sleep. The block enters sleep on the next read of the standby register. The register port is control traffic, so it has no valid/ready handshake. A read or write takes effect in the cycle it is presented, and read data is combinational from the address.

Top module: `pwr_state_seq`

## Requirements
- R1: After rst_n, pwr_state is RUN (encoding RUN=0, SLEEP=1, STOP=2, INIT=3, RST=4). All three clock enables are 1, and both registers read 0.
- R2: In RUN, a write to the standby register (address 0) with bit 7 set enters STOP at the next edge. Bit 7 takes precedence over bit 6 in the same write.
- R3: In STOP, cpu_clk_en, bus_clk_en and per_clk_en are all 0. STOP is left only for an enabled interrupt (to RUN) or a reset request. An interrupt with level 15 leaves it in STOP.
- R4: With the synchronous bit (bit 8 of the timebase register, address 1) clear, writing bit 6 of address 0 in RUN enters SLEEP at the next edge.
- R5: With the synchronous bit set, writing bit 6 keeps the state RUN and makes bit 6 read back as 1. A later read of address 0 enters SLEEP at the edge that ends the read. A read of address 1 does not.
- R6: In SLEEP, any interrupt whose request is 1 and whose level is not 15 returns to RUN at the next edge. A level of 15 does not.
- R7: In SLEEP, cpu_clk_en is 0 and per_clk_en is 1. bus_clk_en equals dma_req in the same cycle.
- R8: init_req enters INIT at the next edge from any state. It has priority over rst_req and over interrupt wake-up.
- R9: rst_req without init_req enters RST at the next edge from any state. It has priority over interrupt wake-up.
- R10: INIT and RST each last exactly 4 cycles after the last request, then go to RUN. All clock enables are 1 during them.
- R11: On return to RUN from SLEEP, STOP, INIT or RST, bits 6 and 7 of the standby register read 0.
- R12: INIT clears the synchronous bit. RST preserves it.
- R13: Register writes while not in RUN are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = standby register, 1 = timebase register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| irq_req | input | 4 | Interrupt request per source |
| irq_lvl | input | 16 | 4-bit level per source, source i at bits 4i+3..4i |
| init_req | input | 1 | Setting-reset request |
| rst_req | input | 1 | Operation-reset request |
| dma_req | input | 1 | DMA transfer request active |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | Bus and memory clock enable |
| per_clk_en | output | 1 | Peripheral domain clock enable |
| pwr_state | output | 3 | Current state code |

## Verification
The bench sweeps every level on every interrupt source in both SLEEP and STOP. A design that compared the level against the wrong value, or ignored one source, would either wake on level 15 or stay asleep on a valid request. It also tries all eight combinations of INIT, RST and wake arriving together in both low-power states, which exposes a swapped priority as the wrong state code. Synchronous standby is checked against early entry on the write, and against entry on a read of the wrong register. The reset holds are timed cycle by cycle to catch an off-by-one hold. The synchronous bit is checked for surviving RST but not INIT.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    PS_RUN   = 3'd0,
    PS_SLEEP = 3'd1,
    PS_STOP  = 3'd2,
    PS_INIT  = 3'd3,
    PS_RST   = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/pwr_wake.sv
// Qualifies interrupt requests: a level of all ones means the source is masked.
module pwr_wake #(
  parameter int N_IRQ = 4,
  parameter int LVL_W = 4
) (
  input  logic [N_IRQ-1:0]       irq_req,
  input  logic [N_IRQ*LVL_W-1:0] irq_lvl,
  output logic                   wake
);
  localparam logic [LVL_W-1:0] LVL_OFF = {LVL_W{1'b1}};

  logic [N_IRQ-1:0] src_ok;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    assign src_ok[i] = irq_req[i] && (irq_lvl[i*LVL_W +: LVL_W] != LVL_OFF);
  end

  assign wake = |src_ok;
endmodule

// File: rtl/pwr_regs.sv
// Standby and timebase control registers plus the entry events they produce.
module pwr_regs #(
  parameter int DW        = 16,
  parameter int STOP_BIT  = 7,
  parameter int SLEEP_BIT = 6,
  parameter int SYNC_BIT  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          in_run,
  input  logic          clr_stby,
  input  logic          clr_sync,
  output logic [DW-1:0] reg_rdata,
  output logic          stop_q,
  output logic          sleep_q,
  output logic          go_stop,
  output logic          go_sleep
);
  logic sync_q;
  logic wr_ok;
  logic wr_stby;
  logic wr_tb;
  logic sync_entry;
  logic plain_entry;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;

  // Writes land only while the CPU runs.
  assign wr_ok   = reg_wr && in_run;
  assign wr_stby = wr_ok && !reg_addr;
  assign wr_tb   = wr_ok && reg_addr;

  assign go_stop = wr_stby && reg_wdata[STOP_BIT];

  // Sleep entry: on the write when not synchronous, on a standby read when armed.
  assign plain_entry = wr_stby && reg_wdata[SLEEP_BIT] && !sync_q;
  assign sync_entry  = in_run && reg_rd && !reg_wr && !reg_addr && sleep_q && sync_q;
  assign go_sleep    = !go_stop && (plain_entry || sync_entry);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q  <= 1'b0;
      sleep_q <= 1'b0;
    end else if (clr_stby) begin
      stop_q  <= 1'b0;
      sleep_q <= 1'b0;
    end else if (wr_stby) begin
      stop_q  <= reg_wdata[STOP_BIT];
      sleep_q <= reg_wdata[SLEEP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
    end else if (clr_sync) begin
      sync_q <= 1'b0;
    end else if (wr_tb) begin
      sync_q <= reg_wdata[SYNC_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr) begin
      reg_rdata[STOP_BIT]  = stop_q;
      reg_rdata[SLEEP_BIT] = sleep_q;
    end else begin
      reg_rdata[SYNC_BIT] = sync_q;
    end
  end
endmodule

// File: rtl/pwr_fsm.sv
// Power state register with reset-hold counter and request priority.
module pwr_fsm
  import pwr_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_req,
  input  logic       rst_req,
  input  logic       wake,
  input  logic       go_stop,
  input  logic       go_sleep,
  output pwr_state_e st,
  output logic       clr_stby,
  output logic       clr_sync
);
  localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

  pwr_state_e       st_n;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (init_req) begin
      st_n  = PS_INIT;
      cnt_n = '0;
    end else if (rst_req) begin
      st_n  = PS_RST;
      cnt_n = '0;
    end else begin
      unique case (st)
        PS_RUN: begin
          if (go_stop)       st_n = PS_STOP;
          else if (go_sleep) st_n = PS_SLEEP;
        end
        PS_SLEEP, PS_STOP: begin
          if (wake) st_n = PS_RUN;
        end
        PS_INIT, PS_RST: begin
          if (cnt == CNT_LAST) st_n = PS_RUN;
          else                 cnt_n = cnt + 1'b1;
        end
        default: st_n = PS_RUN;
      endcase
    end
  end

  assign clr_stby = ((st_n == PS_RUN) && (st != PS_RUN)) ||
                    (st_n == PS_INIT) || (st_n == PS_RST);
  assign clr_sync = (st_n == PS_INIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PS_RUN;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end
endmodule

// File: rtl/pwr_clkgen.sv
// Clock-domain enables decoded from the power state.
module pwr_clkgen
  import pwr_pkg::*;
(
  input  pwr_state_e st,
  input  logic       dma_req,
  output logic       cpu_clk_en,
  output logic       bus_clk_en,
  output logic       per_clk_en
);
  always_comb begin
    cpu_clk_en = 1'b1;
    bus_clk_en = 1'b1;
    per_clk_en = 1'b1;
    unique case (st)
      PS_SLEEP: begin
        cpu_clk_en = 1'b0;
        bus_clk_en = dma_req;
      end
      PS_STOP: begin
        cpu_clk_en = 1'b0;
        bus_clk_en = 1'b0;
        per_clk_en = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pwr_pkg::*;
#(
  parameter int N_IRQ     = 4,
  parameter int LVL_W     = 4,
  parameter int HOLD_CYC  = 4,
  parameter int DW        = 16,
  parameter int STOP_BIT  = 7,
  parameter int SLEEP_BIT = 6,
  parameter int SYNC_BIT  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic                   reg_addr,
  input  logic [DW-1:0]          reg_wdata,
  output logic [DW-1:0]          reg_rdata,
  input  logic [N_IRQ-1:0]       irq_req,
  input  logic [N_IRQ*LVL_W-1:0] irq_lvl,
  input  logic                   init_req,
  input  logic                   rst_req,
  input  logic                   dma_req,
  output logic                   cpu_clk_en,
  output logic                   bus_clk_en,
  output logic                   per_clk_en,
  output logic [2:0]             pwr_state
);
  pwr_state_e st;
  logic       wake;
  logic       go_stop;
  logic       go_sleep;
  logic       clr_stby;
  logic       clr_sync;
  logic       stop_q;
  logic       sleep_q;

  pwr_wake #(.N_IRQ(N_IRQ), .LVL_W(LVL_W)) u_wake (
    .irq_req (irq_req),
    .irq_lvl (irq_lvl),
    .wake    (wake)
  );

  pwr_regs #(
    .DW(DW), .STOP_BIT(STOP_BIT), .SLEEP_BIT(SLEEP_BIT), .SYNC_BIT(SYNC_BIT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .in_run    (st == PS_RUN),
    .clr_stby  (clr_stby),
    .clr_sync  (clr_sync),
    .reg_rdata (reg_rdata),
    .stop_q    (stop_q),
    .sleep_q   (sleep_q),
    .go_stop   (go_stop),
    .go_sleep  (go_sleep)
  );

  pwr_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_req (init_req),
    .rst_req  (rst_req),
    .wake     (wake),
    .go_stop  (go_stop),
    .go_sleep (go_sleep),
    .st       (st),
    .clr_stby (clr_stby),
    .clr_sync (clr_sync)
  );

  pwr_clkgen u_clk (
    .st         (st),
    .dma_req    (dma_req),
    .cpu_clk_en (cpu_clk_en),
    .bus_clk_en (bus_clk_en),
    .per_clk_en (per_clk_en)
  );

  assign pwr_state = st;
endmodule

// File: rtl/pwr_state_seq_chk.sv
module pwr_state_seq_chk #(
  parameter int N_IRQ    = 4,
  parameter int LVL_W    = 4,
  parameter int HOLD_CYC = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_IRQ-1:0]       irq_req,
  input logic [N_IRQ*LVL_W-1:0] irq_lvl,
  input logic                   init_req,
  input logic                   rst_req,
  input logic                   dma_req,
  input logic                   cpu_clk_en,
  input logic                   bus_clk_en,
  input logic                   per_clk_en,
  input logic [2:0]             pwr_state,
  input logic                   stop_q,
  input logic                   sleep_q
);
  localparam logic [2:0] S_RUN = 3'd0, S_SLEEP = 3'd1, S_STOP = 3'd2,
                         S_INIT = 3'd3, S_RST = 3'd4;

  logic       any_ok;
  logic       in_rst;
  logic [7:0] hold_cnt;

  always_comb begin
    any_ok = 1'b0;
    for (int i = 0; i < N_IRQ; i++)
      if (irq_req[i] && irq_lvl[i*LVL_W +: LVL_W] != {LVL_W{1'b1}}) any_ok = 1'b1;
  end

  assign in_rst = (pwr_state == S_INIT) || (pwr_state == S_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hold_cnt <= '0;
    else if (init_req || rst_req) hold_cnt <= 8'd1;
    else if (in_rst)            hold_cnt <= (hold_cnt == 8'hFF) ? hold_cnt : hold_cnt + 8'd1;
    else                        hold_cnt <= '0;
  end

  // R3
  stop_clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == S_STOP |-> !cpu_clk_en && !bus_clk_en && !per_clk_en);
  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == S_STOP && !any_ok && !init_req && !rst_req |=> pwr_state == S_STOP);
  // R7
  sleep_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == S_SLEEP |-> !cpu_clk_en && per_clk_en && (bus_clk_en == dma_req));
  // R6
  sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == S_SLEEP && any_ok && !init_req && !rst_req |=> pwr_state == S_RUN);
  // R6
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == S_SLEEP && !any_ok && !init_req && !rst_req |=> pwr_state == S_SLEEP);
  // R8
  init_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> pwr_state == S_INIT);
  // R9
  rst_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req && !init_req |=> pwr_state == S_RST);
  // R10
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_rst |-> hold_cnt >= 8'd1 && hold_cnt <= 8'(HOLD_CYC));
  // R10
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_rst && hold_cnt == 8'(HOLD_CYC) && !init_req && !rst_req |=> pwr_state == S_RUN);
  // R10
  hold_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_rst |-> cpu_clk_en && bus_clk_en && per_clk_en);
  // R11
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == S_RUN && $past(pwr_state) != S_RUN |-> !stop_q && !sleep_q);
endmodule

bind pwr_state_seq pwr_state_seq_chk #(
  .N_IRQ(N_IRQ), .LVL_W(LVL_W), .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_req    (irq_req),
  .irq_lvl    (irq_lvl),
  .init_req   (init_req),
  .rst_req    (rst_req),
  .dma_req    (dma_req),
  .cpu_clk_en (cpu_clk_en),
  .bus_clk_en (bus_clk_en),
  .per_clk_en (per_clk_en),
  .pwr_state  (pwr_state),
  .stop_q     (stop_q),
  .sleep_q    (sleep_q)
);

// File: tb/test_pwr_state_seq.sv
module test_pwr_state_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  irq_req = '0;
  logic [15:0] irq_lvl = '1;
  logic        init_req = 1'b0, rst_req = 1'b0, dma_req = 1'b0;
  logic        cpu_clk_en, bus_clk_en, per_clk_en;
  logic [2:0]  pwr_state;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_seq i_pwr_state_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_lvl(irq_lvl), .init_req(init_req),
    .rst_req(rst_req), .dma_req(dma_req), .cpu_clk_en(cpu_clk_en),
    .bus_clk_en(bus_clk_en), .per_clk_en(per_clk_en), .pwr_state(pwr_state)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic a);
    reg_rd = 1'b1; reg_addr = a;
    step();
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic a);
    reg_addr = a;
    #1;
  endtask

  task automatic wake_lvl0();
    irq_req = 4'b0001; irq_lvl = 16'hFFF0;
    step();
    irq_req = '0; irq_lvl = '1;
  endtask

  task automatic wait_run();
    for (int k = 0; k < 10 && pwr_state != 3'd0; k++) step();
  endtask

  // full reset hold: state seen as code for HOLD samples, then RUN (R10)
  task automatic hold_seq(input int code, input string tag);
    chk({tag, " entry"}, pwr_state, code);
    chk("R10 clocks on in hold", {cpu_clk_en, bus_clk_en, per_clk_en}, 7);
    for (int k = 1; k < HOLD; k++) begin
      step();
      chk("R10 hold length", pwr_state, code);
    end
    step();
    chk("R10 exit to RUN", pwr_state, 0);
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 state", pwr_state, 0);
    chk("R1 clocks", {cpu_clk_en, bus_clk_en, per_clk_en}, 7);
    peek(0); chk("R1 standby reg", reg_rdata, 0);
    peek(1); chk("R1 timebase reg", reg_rdata, 0);

    // R4 plain sleep entry, R7 clocks, R13 write ignored
    wr(0, 16'h0040);
    chk("R4 sleep entry", pwr_state, 1);
    peek(0); chk("R4 sleep bit", reg_rdata, 16'h0040);
    for (int d = 0; d < 2; d++) begin
      dma_req = d[0]; #1;
      chk("R7 cpu off", cpu_clk_en, 0);
      chk("R7 per on", per_clk_en, 1);
      chk("R7 bus follows dma", bus_clk_en, d);
    end
    dma_req = 1'b0;
    wr(1, 16'h0100);
    chk("R13 still sleeping", pwr_state, 1);
    wake_lvl0();
    chk("R6 wake", pwr_state, 0);
    peek(1); chk("R13 write in sleep ignored", reg_rdata, 0);
    peek(0); chk("R11 bits cleared", reg_rdata, 0);

    // R6 / R3 level sweep over every source in SLEEP and STOP
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int l = 0; l < 16; l++) begin
          int exp_st;
          wr(0, m ? 16'h0080 : 16'h0040);
          if (m) chk("R3 stop clocks off", {cpu_clk_en, bus_clk_en, per_clk_en}, 0);
          irq_req = 4'(1 << s);
          irq_lvl = '1;
          irq_lvl[s*4 +: 4] = l[3:0];
          step();
          irq_req = '0; irq_lvl = '1;
          exp_st = (l != 15) ? 0 : (m ? 2 : 1);
          chk(m ? "R3 stop level sweep" : "R6 sleep level sweep", pwr_state, exp_st);
          if (pwr_state != 3'd0) wake_lvl0();
          peek(0); chk("R11 bits after wake", reg_rdata, 0);
        end
      end
    end

    // R2 stop wins over sleep in the same write
    wr(0, 16'h00C0);
    chk("R2 stop precedence", pwr_state, 2);
    wake_lvl0();

    // R5 synchronous standby
    wr(1, 16'h0100);
    wr(0, 16'h0040);
    chk("R5 write alone stays RUN", pwr_state, 0);
    peek(0); chk("R5 sleep bit armed", reg_rdata, 16'h0040);
    rd(1);
    chk("R5 timebase read no entry", pwr_state, 0);
    rd(0);
    chk("R5 standby read enters", pwr_state, 1);
    wake_lvl0();

    // R12 RST keeps sync bit, INIT clears it
    rst_req = 1'b1; step(); rst_req = 1'b0;
    hold_seq(4, "R9 RST");
    peek(1); chk("R12 RST keeps sync", reg_rdata, 16'h0100);
    init_req = 1'b1; step(); init_req = 1'b0;
    hold_seq(3, "R8 INIT");
    peek(1); chk("R12 INIT clears sync", reg_rdata, 0);

    // R8 / R9 priority sweep in SLEEP and STOP
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 8; c++) begin
        int exp_st;
        wr(0, m ? 16'h0080 : 16'h0040);
        init_req = c[2]; rst_req = c[1];
        irq_req = {3'b000, c[0]}; irq_lvl = 16'hFFF3;
        step();
        init_req = 1'b0; rst_req = 1'b0; irq_req = '0; irq_lvl = '1;
        exp_st = c[2] ? 3 : (c[1] ? 4 : (c[0] ? 0 : (m ? 2 : 1)));
        chk(c[2] ? "R8 INIT priority" : "R9 RST priority", pwr_state, exp_st);
        if (pwr_state == 3'd1 || pwr_state == 3'd2) wake_lvl0();
        wait_run();
        chk("R10 back to RUN", pwr_state, 0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule